// File: doc/BRIEF.md
# Dynamic Bus Sizing Master

This block moves one datum of one to four bytes between an internal requester and an external, non-burst bus. It assumes a 32-bit memory at first. If the addressed memory reports a narrow data path of 8 or 16 bits, the block turns the single request into a run of narrow transactions. It keeps issuing them until every requested byte has crossed the bus, and it does so without giving up ownership of the bus in between.

The internal side presents an address, a byte count, a direction and a write word for one cycle while the block is idle. It receives a single completion pulse with the read word and an error flag. Bytes are numbered from the most significant end of the 32-bit word. Narrow memories always exchange data on the most significant byte lanes of the bus.

A retry on the opening transaction sends the block back to bus arbitration and starts the transfer again. A retry on any later transaction of a narrow sequence cannot be repaired, so the block ends the transfer at once and flags a fatal error.

Top module: `dynsize_bus_master`

## Requirements
- R1: While reset is low and in the first cycle after it is released, bus_req_o, bus_busy_o, ts_o, rsp_done, rsp_err and rsp_rdata are all zero.
- R2: A request taken while idle raises bus_req_o in the next cycle. The block asserts bus_busy_o together with a one-cycle ts_o only in the cycle after it samples bus_grant_i high with bus_busy_i low. As long as bus_busy_i stays high, it keeps requesting and never drives the bus.
- R3: The size field uses 01 for one byte, 10 for two, 11 for three and 00 for four. The opening transaction places req_addr on addr_o and req_size on tsize_o, and rnw_o is high for reads.
- R4: psize_i is sampled together with the acknowledge of the opening transaction: 01 means an 8-bit port, 10 a 16-bit port, and 00 or 11 a 32-bit port. With a 32-bit port the transfer ends after that one transaction.
- R5: With a narrow port, the block starts one follow-on transaction per remaining group of port-width bytes. Transaction k uses the address req_addr plus the byte offset it covers, and a size of the remaining bytes capped at the port width.
- R6: All transactions of one transfer are atomic. bus_busy_o stays high and bus_req_o stays low from the first ts_o through the final acknowledge.
- R7: On writes, wdata_o carries the write word shifted left by the byte offset of the transaction. Request byte at offset o therefore appears on bits 31:24, and the byte at o+1 on bits 23:16.
- R8: Wait states are inserted until ack_i is sampled. addr_o stays constant throughout a transaction.
- R9: On reads, the byte on bus lane i (lane 0 = bits 31:24) is stored at request offset o+i, for i below the port width and o+i below the byte count. Bytes outside the request read as zero, and data on unused lanes is ignored.
- R10: retry_i on the opening transaction releases the bus and repeats the whole transfer from arbitration, with no error reported.
- R11: retry_i on any later transaction ends the transfer and gives rsp_done together with rsp_err.
- R12: rsp_done is a single one-cycle pulse, in the cycle after the edge that samples the final ack_i or the fatal retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_addr | input | AW | Byte address of the first byte |
| req_size | input | 2 | Byte count encoding |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word, first byte in bits 31:24 |
| rsp_rdata | output | 32 | Read word, packed from bits 31:24 |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Fatal retry flag, valid with rsp_done |
| bus_req_o | output | 1 | Bus request |
| bus_grant_i | input | 1 | Bus grant |
| bus_busy_i | input | 1 | Another master still owns the bus |
| bus_busy_o | output | 1 | This master owns the bus |
| ts_o | output | 1 | Transfer start strobe |
| addr_o | output | AW | Transaction address |
| rnw_o | output | 1 | 1 = read transaction |
| tsize_o | output | 2 | Transaction size |
| wdata_o | output | 32 | Write data lanes |
| rdata_i | input | 32 | Read data lanes |
| ack_i | input | 1 | Transfer acknowledge |
| retry_i | input | 1 | Transfer retry |
| psize_i | input | 2 | Port width indication |

## Verification
The bench covers three-byte transfers on a 16-bit port, where the second transaction has to shrink to a one-byte size. A design that kept the port width as the size would then move a byte that was never requested. It also covers a single byte on a 16-bit port, which must finish in one transaction and not start a second one that goes nowhere. Reads return image bytes on the lanes a narrow port does not use, so a design that packs those lanes shows corrupted data. Retries are placed on the opening, second and fourth transactions: a block that treated every retry alike would either hang on restarts or report false fatal errors. A bus held busy by another master shows whether the block starts a transfer on the grant alone.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  localparam int DSB_DW = 32;
  localparam int DSB_NB = DSB_DW / 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARB   = 2'd1,
    ST_START = 2'd2,
    ST_WAIT  = 2'd3
  } dsb_state_e;

  // size code to byte count: 00 means four bytes
  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction

  // byte count (1..4) to size code
  function automatic logic [1:0] bytes_to_size(input logic [2:0] cnt);
    return cnt[1:0];
  endfunction

  // port indication to width in bytes
  function automatic logic [2:0] port_width(input logic [1:0] ps);
    logic [2:0] w;
    case (ps)
      2'b01:   w = 3'd1;
      2'b10:   w = 3'd2;
      default: w = 3'd4;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/dsb_lane_mux.sv
module dsb_lane_mux
  import dsb_pkg::*;
#(
  parameter int DW = DSB_DW
) (
  input  logic [DW-1:0] wr_word,
  input  logic [DW-1:0] rd_word_cur,
  input  logic [DW-1:0] bus_rd_lanes,
  input  logic [2:0]    byte_off,
  input  logic [2:0]    port_w,
  input  logic [2:0]    xfer_bytes,
  output logic [DW-1:0] bus_wr_lanes,
  output logic [DW-1:0] rd_word_next
);

  localparam int NB   = DW / 8;
  localparam int SHW  = $clog2(DW) + 1;

  logic [SHW-1:0] lane_shift;
  logic [DW-1:0]  rd_aligned;
  logic [3:0]     span_end;

  assign lane_shift   = SHW'({byte_off, 3'b000});
  assign bus_wr_lanes = wr_word << lane_shift;
  assign rd_aligned   = bus_rd_lanes >> lane_shift;
  assign span_end     = {1'b0, byte_off} + {1'b0, port_w};

  for (genvar j = 0; j < NB; j++) begin : g_byte
    localparam logic [3:0] JPOS = 4'(j);
    logic take_byte;
    assign take_byte = (JPOS >= {1'b0, byte_off}) && (JPOS < span_end) &&
                       (JPOS < {1'b0, xfer_bytes});
    assign rd_word_next[DW-1-8*j -: 8] = take_byte ? rd_aligned[DW-1-8*j -: 8]
                                                   : rd_word_cur[DW-1-8*j -: 8];
  end

endmodule

// File: rtl/dsb_seq_ctrl.sv
module dsb_seq_ctrl
  import dsb_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic          bus_grant_i,
  input  logic          bus_busy_i,
  input  logic          ack_i,
  input  logic          retry_i,
  input  logic [1:0]    psize_i,
  output logic          bus_req_o,
  output logic          bus_busy_o,
  output logic          ts_o,
  output logic [AW-1:0] addr_o,
  output logic          rnw_o,
  output logic [1:0]    tsize_o,
  output logic          wr_o,
  output logic [2:0]    off_o,
  output logic [2:0]    eff_w_o,
  output logic [2:0]    nbytes_o,
  output logic          accept_o,
  output logic          rd_cap_o,
  output logic          done_o,
  output logic          err_o
);

  dsb_state_e    st_q, st_d;
  logic [AW-1:0] base_q;
  logic [1:0]    size_q;
  logic          wr_q;
  logic [2:0]    off_q, off_d;
  logic [2:0]    w_q, w_d;
  logic          first_q, first_d;
  logic          done_q, done_d;
  logic          err_q, err_d;

  logic [2:0] nbytes, eff_w, remain, chunk;
  logic [3:0] reach;
  logic       last_txn, take_ack, take_retry, accept;

  assign nbytes     = size_to_bytes(size_q);
  assign eff_w      = first_q ? port_width(psize_i) : w_q;
  assign reach      = {1'b0, off_q} + {1'b0, eff_w};
  assign last_txn   = reach >= {1'b0, nbytes};
  assign remain     = nbytes - off_q;
  assign chunk      = (remain < w_q) ? remain : w_q;
  assign accept     = (st_q == ST_IDLE) && req_valid;
  assign take_retry = (st_q == ST_WAIT) && retry_i;
  assign take_ack   = (st_q == ST_WAIT) && ack_i && !retry_i;

  always_comb begin
    st_d    = st_q;
    off_d   = off_q;
    w_d     = w_q;
    first_d = first_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d    = ST_ARB;
          off_d   = 3'd0;
          w_d     = 3'd4;
          first_d = 1'b1;
        end
      end
      ST_ARB: begin
        if (bus_grant_i && !bus_busy_i) st_d = ST_START;
      end
      ST_START: st_d = ST_WAIT;
      ST_WAIT: begin
        if (take_retry) begin
          if (first_q) begin
            st_d = ST_ARB;
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            err_d  = 1'b1;
          end
        end else if (take_ack) begin
          if (first_q) w_d = eff_w;
          if (last_txn) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d    = ST_START;
            off_d   = reach[2:0];
            first_d = 1'b0;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      off_q   <= 3'd0;
      w_q     <= 3'd4;
      first_q <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      off_q   <= off_d;
      w_q     <= w_d;
      first_q <= first_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= 2'b00;
      wr_q   <= 1'b0;
    end else if (accept) begin
      base_q <= req_addr;
      size_q <= req_size;
      wr_q   <= req_write;
    end
  end

  assign bus_req_o  = (st_q == ST_ARB);
  assign bus_busy_o = (st_q == ST_START) || (st_q == ST_WAIT);
  assign ts_o       = (st_q == ST_START);
  assign addr_o     = bus_busy_o ? base_q + AW'(off_q) : '0;
  assign rnw_o      = bus_busy_o && !wr_q;
  assign tsize_o    = !bus_busy_o ? 2'b00 :
                      first_q     ? size_q : bytes_to_size(chunk);
  assign wr_o       = bus_busy_o && wr_q;
  assign off_o      = off_q;
  assign eff_w_o    = eff_w;
  assign nbytes_o   = nbytes;
  assign accept_o   = accept;
  assign rd_cap_o   = take_ack && !wr_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

endmodule

// File: rtl/dynsize_bus_master.sv
module dynsize_bus_master
  import dsb_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [31:0]   req_wdata,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic          bus_req_o,
  input  logic          bus_grant_i,
  input  logic          bus_busy_i,
  output logic          bus_busy_o,
  output logic          ts_o,
  output logic [AW-1:0] addr_o,
  output logic          rnw_o,
  output logic [1:0]    tsize_o,
  output logic [31:0]   wdata_o,
  input  logic [31:0]   rdata_i,
  input  logic          ack_i,
  input  logic          retry_i,
  input  logic [1:0]    psize_i
);

  logic        wr_act, accept, rd_cap;
  logic [2:0]  off, eff_w, nbytes;
  logic [31:0] wword_q, rword_q, rword_d, lanes_out;

  dsb_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_write  (req_write),
    .bus_grant_i(bus_grant_i),
    .bus_busy_i (bus_busy_i),
    .ack_i      (ack_i),
    .retry_i    (retry_i),
    .psize_i    (psize_i),
    .bus_req_o  (bus_req_o),
    .bus_busy_o (bus_busy_o),
    .ts_o       (ts_o),
    .addr_o     (addr_o),
    .rnw_o      (rnw_o),
    .tsize_o    (tsize_o),
    .wr_o       (wr_act),
    .off_o      (off),
    .eff_w_o    (eff_w),
    .nbytes_o   (nbytes),
    .accept_o   (accept),
    .rd_cap_o   (rd_cap),
    .done_o     (rsp_done),
    .err_o      (rsp_err)
  );

  dsb_lane_mux #(.DW(DSB_DW)) u_lanes (
    .wr_word     (wword_q),
    .rd_word_cur (rword_q),
    .bus_rd_lanes(rdata_i),
    .byte_off    (off),
    .port_w      (eff_w),
    .xfer_bytes  (nbytes),
    .bus_wr_lanes(lanes_out),
    .rd_word_next(rword_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wword_q <= '0;
    end else if (accept) begin
      wword_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rword_q <= '0;
    end else if (accept) begin
      rword_q <= '0;
    end else if (rd_cap) begin
      rword_q <= rword_d;
    end
  end

  assign wdata_o   = wr_act ? lanes_out : '0;
  assign rsp_rdata = rword_q;

endmodule

// File: rtl/dsb_chk.sv
module dsb_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req_o,
  input logic          bus_grant_i,
  input logic          bus_busy_i,
  input logic          bus_busy_o,
  input logic          ts_o,
  input logic [AW-1:0] addr_o,
  input logic          ack_i,
  input logic          retry_i,
  input logic          rsp_done,
  input logic          rsp_err
);

  // R2
  ts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ts_o |=> !ts_o);

  // R2
  own_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy_o) |-> $past(bus_grant_i && !bus_busy_i));

  // R6
  atomic_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy_o) |-> (rsp_done || bus_req_o));

  // R6
  no_req_while_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_o |-> !bus_req_o);

  // R8
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy_o && !ts_o) |-> $stable(addr_o));

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R12
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(ack_i || retry_i));

endmodule

bind dynsize_bus_master dsb_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req_o  (bus_req_o),
  .bus_grant_i(bus_grant_i),
  .bus_busy_i (bus_busy_i),
  .bus_busy_o (bus_busy_o),
  .ts_o       (ts_o),
  .addr_o     (addr_o),
  .ack_i      (ack_i),
  .retry_i    (retry_i),
  .rsp_done   (rsp_done),
  .rsp_err    (rsp_err)
);

// File: tb/dynsize_bus_master_tb.sv
`timescale 1ns/1ps
module dynsize_bus_master_tb;

  localparam int AW = 24;

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [23:0] adr;
    logic [31:0] wd;
    logic [31:0] img;
    logic [1:0]  ps;
    logic [1:0]  ws;
    logic [3:0]  rty;   // transaction index that gets retry, F = none
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'b00, 24'h001000, 32'h0,        32'hA1B2C3D4, 2'b00, 2'd0, 4'hF},
    '{1'b1, 2'b00, 24'h002000, 32'h11223344, 32'h0,        2'b01, 2'd1, 4'hF},
    '{1'b0, 2'b00, 24'h003000, 32'h0,        32'h5566778D, 2'b10, 2'd0, 4'hF},
    '{1'b1, 2'b11, 24'h004001, 32'hCAFEBE00, 32'h0,        2'b10, 2'd2, 4'hF},
    '{1'b0, 2'b11, 24'h005000, 32'h0,        32'h9ABCDEF1, 2'b01, 2'd0, 4'hF},
    '{1'b1, 2'b10, 24'h006002, 32'hBEEF7777, 32'h0,        2'b00, 2'd1, 4'hF},
    '{1'b0, 2'b01, 24'h007003, 32'h0,        32'h7E5A3C2B, 2'b10, 2'd0, 4'hF},
    '{1'b0, 2'b00, 24'h008000, 32'h0,        32'h0F1E2D3C, 2'b01, 2'd1, 4'h0},
    '{1'b1, 2'b00, 24'h009000, 32'hDEADF00D, 32'h0,        2'b10, 2'd0, 4'h1},
    '{1'b0, 2'b00, 24'h00A000, 32'h0,        32'h13572468, 2'b01, 2'd0, 4'h3}
  };

  logic          clk, rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [31:0]   req_wdata, rsp_rdata;
  logic          rsp_done, rsp_err;
  logic          bus_req_o, bus_grant_i, bus_busy_i, bus_busy_o, ts_o, rnw_o;
  logic [AW-1:0] addr_o;
  logic [1:0]    tsize_o, psize_i;
  logic [31:0]   wdata_o, rdata_i;
  logic          ack_i, retry_i;

  dynsize_bus_master #(.AW(AW)) u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [1:0] s);
    return (s == 2'b00) ? 4 : int'(s);
  endfunction

  function automatic int w_of(input logic [1:0] p);
    return (p == 2'b01) ? 1 : (p == 2'b10) ? 2 : 4;
  endfunction

  function automatic logic [31:0] top_mask(input int n);
    return ~(32'hFFFF_FFFF >> (8 * n));
  endfunction

  // responder state
  logic        cur_wr;
  logic [1:0]  cur_sz, cur_ps;
  logic [23:0] cur_adr;
  logic [31:0] cur_img, wcap, rdata_seen;
  int          cur_ws, cur_rty, cur_n, cur_w;
  int          off, tx_cnt, done_cnt, wc, nc, fin_nc;
  bit          pend, err_seen;
  logic [23:0] tx_addr;

  always @(negedge clk) begin
    nc = nc + 1;
    bus_grant_i = bus_req_o;
    ack_i = 1'b0; retry_i = 1'b0; rdata_i = '0; psize_i = 2'b00;
    if (!rst_n) begin
      pend = 1'b0;
    end else begin
      if (rsp_done) begin
        done_cnt++;
        err_seen   = rsp_err;
        rdata_seen = rsp_rdata;
        chk(nc == fin_nc + 1, "R12 done timing", nc, fin_nc + 1);
      end
      if (ts_o) begin
        int cnt;
        logic [1:0] exp_sz;
        cnt = (cur_n - off < cur_w) ? cur_n - off : cur_w;
        exp_sz = (off == 0) ? cur_sz : 2'(cnt);
        chk(addr_o == cur_adr + 24'(off), "R5 address", 32'(addr_o), 32'(cur_adr + 24'(off)));
        chk(tsize_o == exp_sz, "R5 size", 32'(tsize_o), 32'(exp_sz));
        chk(rnw_o == !cur_wr, "R3 direction", 32'(rnw_o), 32'(!cur_wr));
        for (int i = 0; i < cnt; i++)
          wcap[31 - 8*(off+i) -: 8] = wdata_o[31 - 8*i -: 8];
        tx_addr = addr_o;
        tx_cnt++;
        wc = cur_ws;
        pend = 1'b1;
      end else if (pend) begin
        chk(addr_o == tx_addr, "R8 address held", 32'(addr_o), 32'(tx_addr));
        if (wc == 0) begin
          pend = 1'b0;
          if (tx_cnt - 1 == cur_rty) begin
            retry_i = 1'b1;
            if (off != 0) fin_nc = nc;
          end else begin
            ack_i   = 1'b1;
            psize_i = cur_ps;
            rdata_i = (cur_w == 4) ? cur_img : (cur_img << (8 * off));
            off = off + cur_w;
            if (off >= cur_n) fin_nc = nc;
          end
        end else begin
          wc--;
        end
      end
    end
  end

  task automatic run_vec(input int k, input bit hold_busy);
    vec_t v;
    int exp_tx;
    bit exp_err;
    v = TBL[k];
    cur_wr = v.wr; cur_sz = v.sz; cur_adr = v.adr; cur_img = v.img; cur_ps = v.ps;
    cur_ws = int'(v.ws); cur_rty = (v.rty == 4'hF) ? -1 : int'(v.rty);
    cur_n = nb_of(v.sz); cur_w = w_of(v.ps);
    off = 0; tx_cnt = 0; done_cnt = 0; wcap = '0; fin_nc = -100; err_seen = 1'b0;
    if (hold_busy) bus_busy_i = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.adr; req_size = v.sz; req_wdata = v.wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_req_o == 1'b1, "R2 request raised", 32'(bus_req_o), 32'd1);
    if (hold_busy) begin
      repeat (5) @(negedge clk);
      chk(bus_busy_o == 1'b0 && ts_o == 1'b0 && bus_req_o == 1'b1, "R2 waits for busy release",
          {bus_req_o, bus_busy_o, ts_o}, 32'b100);
      bus_busy_i = 1'b0;
    end
    for (int t = 0; t < 300 && done_cnt == 0; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    if (cur_rty < 0)       exp_tx = (cur_n + cur_w - 1) / cur_w;
    else if (cur_rty == 0) exp_tx = (cur_n + cur_w - 1) / cur_w + 1;
    else                   exp_tx = cur_rty + 1;
    exp_err = (cur_rty > 0);
    chk(done_cnt == 1, "R12 one done pulse", done_cnt, 1);
    chk(tx_cnt == exp_tx, "R4 R5 R10 transaction count", tx_cnt, exp_tx);
    chk(err_seen == exp_err, exp_err ? "R11 fatal retry" : "R10 no error", 32'(err_seen), 32'(exp_err));
    if (!exp_err) begin
      if (v.wr) chk(wcap == (v.wd & top_mask(cur_n)), "R7 write lanes", wcap, v.wd & top_mask(cur_n));
      else      chk(rdata_seen == (v.img & top_mask(cur_n)), "R9 read packing", rdata_seen,
                    v.img & top_mask(cur_n));
    end
    chk(bus_busy_o == 1'b0 && bus_req_o == 1'b0, "R6 bus released at end",
        {bus_req_o, bus_busy_o}, 32'd0);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    nc = 0; pend = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 2'b00;
    req_wdata = '0; bus_busy_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({bus_req_o, bus_busy_o, ts_o, rsp_done, rsp_err} == 5'b0 && rsp_rdata == '0,
        "R1 reset outputs", {bus_req_o, bus_busy_o, ts_o, rsp_done, rsp_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({bus_req_o, bus_busy_o, ts_o, rsp_done, rsp_err} == 5'b0 && rsp_rdata == '0,
        "R1 after release", {bus_req_o, bus_busy_o, ts_o, rsp_done, rsp_err}, 32'd0);
    // table walk: R3 R4 R5 R7 R8 R9 R10 R11 R12
    for (int k = 0; k < NV; k++) run_vec(k, 1'b0);
    // directed: R2 other master keeps the bus busy
    run_vec(0, 1'b1);
    // directed: narrow three-byte read after a fatal retry (state fully restarts)
    run_vec(9, 1'b0);
    run_vec(4, 1'b0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule